// File: doc/BRIEF.md
# Coherence Directory With Randomised Capacity Eviction

This block is a directory that records, for each line held in the private caches of a small cluster of cores, which cores currently hold it. Cores send shareable read requests to it. A request for a line that nobody else holds is answered from memory. A request for a line that another core holds is forwarded to one of those holders, which supplies the data. After that transfer the requester is added to the line's holder set, and the line is also placed in the shared cache.

The directory is set-associative and its capacity is fixed. When a new line maps to a set whose ways are all in use, a victim way is chosen at random by a free-running LFSR. Every core that holds the victim line receives a back-invalidation, and the new line takes the victim's place. Until all of those cores have acknowledged, the block stalls any request for the victim line and any request that would need a second eviction.

A pressure monitor counts capacity evictions over a sliding window. With hysteresis, it raises a no-allocate indication that tells the shared cache to let core evictions bypass it.

Top module: `snoop_filter`

## Requirements
- R1: While reset is held and just after it, rsp_valid, fwd_valid, fill_valid, every binv_valid bit and noalloc are 0, and req_ready is 1.
- R2: A request is accepted on a clock edge where req_valid and req_ready are both 1. rsp_valid pulses for exactly one cycle, in the cycle after acceptance, carrying the requester and the line. A miss in a set that still has a free way returns source code 0 (memory) and fills the lowest-numbered free way.
- R3: A request for a tracked line that the requester does not hold, but other cores do, returns source code 1 (peer). In the same cycle, fwd_valid pulses with fwd_core set to the lowest-numbered holder other than the requester, and fwd_line set to the line.
- R4: After such a forward, the requester is recorded as a holder of the line. fill_valid pulses in the same cycle as fwd_valid, with the same line.
- R5: A request from a core that already holds the line returns source code 2 (own). It causes no forward and no fill.
- R6: A miss in a set with every way in use replaces way number lfsr[1:0], using the LFSR value at the accepting edge. binv_valid is set to the victim's holder vector, binv_line to the victim line, and the response returns source code 0. The victim line is then untracked.
- R7: Each binv_valid bit stays at 1 until its core drives binv_ack. It is 0 from the cycle after that acknowledge, and the other bits are not affected.
- R8: While any binv_valid bit is 1, req_ready is 0 for a request to binv_line and for a request that would need another eviction. Other requests are accepted.
- R9: The LFSR is 16 bits wide and reset to 16'hACE1. It advances on every clock edge, shifting left and taking as its new bit 0 the XOR of bits 15, 13, 12 and 10.
- R10: The eviction count covers the capacity evictions accepted in the last 256 clock edges. noalloc is set once the count exceeds thr_hi. It is cleared once the count is below thr_lo, and it holds its value in between.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| req_valid | input | 1 | Shareable read request present |
| req_ready | output | 1 | Request can be accepted this cycle |
| req_core | input | 2 | Requesting core |
| req_line | input | 12 | Requested line address; the low 3 bits select the set |
| rsp_valid | output | 1 | Response pulse |
| rsp_core | output | 2 | Core the response goes to |
| rsp_line | output | 12 | Line of the response |
| rsp_src | output | 2 | 0 memory, 1 peer, 2 own |
| fwd_valid | output | 1 | Supply request to a holding core |
| fwd_core | output | 2 | Core that must supply the line |
| fwd_line | output | 12 | Line to supply |
| fill_valid | output | 1 | Allocate the transferred line in the shared cache |
| fill_line | output | 12 | Line to allocate |
| binv_valid | output | 4 | Back-invalidation pending, one bit per core |
| binv_line | output | 12 | Line being back-invalidated |
| binv_ack | input | 4 | Back-invalidation acknowledge, one bit per core |
| thr_hi | input | 9 | Count above which no-allocate is entered |
| thr_lo | input | 9 | Count below which no-allocate is left |
| noalloc | output | 1 | Shared cache should not allocate core evictions |

## Verification
A wrong holder vector in the directory becomes visible on the next request to that line. It shows up in the cycle after acceptance as the wrong source code, a missing or misdirected forward, or an incorrect back-invalidation vector. A wrong victim choice or a replacement that is lost shows at the eviction itself, and again when the victim line is next requested. That request must miss and evict once more. Pending-state errors show immediately: req_ready differs from what the pending line predicts, or binv bits survive or vanish without the matching acknowledge. A miscounted window shows as noalloc changing on the wrong side of a threshold.

// File: rtl/snf_pkg.sv
package snf_pkg;
  typedef enum logic [1:0] {
    SRC_MEM  = 2'd0,
    SRC_PEER = 2'd1,
    SRC_OWN  = 2'd2
  } src_e;

  localparam int          RND_W    = 16;
  localparam logic [15:0] RND_SEED = 16'hACE1;

  // one step of the maximal-length sequence (taps 16,14,13,11)
  function automatic logic [15:0] rnd_step(input logic [15:0] s);
    return {s[14:0], s[15] ^ s[13] ^ s[12] ^ s[10]};
  endfunction
endpackage

// File: rtl/snf_lfsr.sv
module snf_lfsr
  import snf_pkg::*;
(
  input  logic             clk,
  input  logic             rst_n,
  output logic [RND_W-1:0] state
);
  logic [RND_W-1:0] state_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) state_q <= RND_SEED;
    else        state_q <= rnd_step(state_q);
  end

  assign state = state_q;
endmodule

// File: rtl/snf_pressure.sv
module snf_pressure #(
  parameter int WIN   = 256,
  parameter int CNT_W = $clog2(WIN + 1)
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             ev,
  input  logic [CNT_W-1:0] thr_hi,
  input  logic [CNT_W-1:0] thr_lo,
  output logic [CNT_W-1:0] cnt,
  output logic             noalloc
);
  logic [WIN-1:0]   hist_q;
  logic [CNT_W-1:0] cnt_q;
  logic             na_q;
  logic             aged;

  assign aged = hist_q[WIN-1];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      hist_q <= '0;
      cnt_q  <= '0;
      na_q   <= 1'b0;
    end else begin
      hist_q <= {hist_q[WIN-2:0], ev};
      cnt_q  <= cnt_q + CNT_W'(ev) - CNT_W'(aged);
      if (cnt_q > thr_hi)      na_q <= 1'b1;
      else if (cnt_q < thr_lo) na_q <= 1'b0;
    end
  end

  assign cnt     = cnt_q;
  assign noalloc = na_q;
endmodule

// File: rtl/snf_dir.sv
module snf_dir #(
  parameter int NCORES = 4,
  parameter int TAG_W  = 9,
  parameter int SET_W  = 3,
  parameter int WAY_W  = 2,
  localparam int SETS  = 1 << SET_W,
  localparam int WAYS  = 1 << WAY_W
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [SET_W-1:0]  lk_set,
  input  logic [TAG_W-1:0]  lk_tag,
  input  logic [WAY_W-1:0]  vic_way,
  output logic              hit,
  output logic [WAY_W-1:0]  hit_way,
  output logic [NCORES-1:0] hit_pres,
  output logic              full,
  output logic [WAY_W-1:0]  free_way,
  output logic [TAG_W-1:0]  vic_tag,
  output logic [NCORES-1:0] vic_pres,
  input  logic              wr_en,
  input  logic [WAY_W-1:0]  wr_way,
  input  logic [NCORES-1:0] wr_pres
);
  logic [TAG_W-1:0]  tag_q  [SETS][WAYS];
  logic [NCORES-1:0] pres_q [SETS][WAYS];
  logic              vld_q  [SETS][WAYS];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int s = 0; s < SETS; s++)
        for (int w = 0; w < WAYS; w++)
          vld_q[s][w] <= 1'b0;
    end else if (wr_en) begin
      vld_q[lk_set][wr_way] <= 1'b1;
    end
  end

  always_ff @(posedge clk) begin
    if (wr_en) begin
      tag_q[lk_set][wr_way]  <= lk_tag;
      pres_q[lk_set][wr_way] <= wr_pres;
    end
  end

  always_comb begin
    hit      = 1'b0;
    hit_way  = '0;
    hit_pres = '0;
    full     = 1'b1;
    free_way = '0;
    for (int w = WAYS - 1; w >= 0; w--) begin
      if (vld_q[lk_set][w] && tag_q[lk_set][w] == lk_tag) begin
        hit      = 1'b1;
        hit_way  = WAY_W'(w);
        hit_pres = pres_q[lk_set][w];
      end
      if (!vld_q[lk_set][w]) begin
        full     = 1'b0;
        free_way = WAY_W'(w);
      end
    end
    vic_tag  = tag_q[lk_set][vic_way];
    vic_pres = pres_q[lk_set][vic_way];
  end
endmodule

// File: rtl/snoop_filter.sv
module snoop_filter
  import snf_pkg::*;
#(
  parameter int NCORES = 4,
  parameter int LINE_W = 12,
  parameter int SET_W  = 3,
  parameter int WAY_W  = 2,
  parameter int WIN    = 256,
  localparam int CID_W = $clog2(NCORES),
  localparam int TAG_W = LINE_W - SET_W,
  localparam int CNT_W = $clog2(WIN + 1)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              req_valid,
  output logic              req_ready,
  input  logic [CID_W-1:0]  req_core,
  input  logic [LINE_W-1:0] req_line,
  output logic              rsp_valid,
  output logic [CID_W-1:0]  rsp_core,
  output logic [LINE_W-1:0] rsp_line,
  output logic [1:0]        rsp_src,
  output logic              fwd_valid,
  output logic [CID_W-1:0]  fwd_core,
  output logic [LINE_W-1:0] fwd_line,
  output logic              fill_valid,
  output logic [LINE_W-1:0] fill_line,
  output logic [NCORES-1:0] binv_valid,
  output logic [LINE_W-1:0] binv_line,
  input  logic [NCORES-1:0] binv_ack,
  input  logic [CNT_W-1:0]  thr_hi,
  input  logic [CNT_W-1:0]  thr_lo,
  output logic              noalloc
);
  function automatic logic [CID_W-1:0] lowest_core(input logic [NCORES-1:0] v);
    logic [CID_W-1:0] r;
    r = '0;
    for (int i = NCORES - 1; i >= 0; i--)
      if (v[i]) r = CID_W'(i);
    return r;
  endfunction

  logic [SET_W-1:0]  set_idx;
  logic [TAG_W-1:0]  tag_val;
  logic [NCORES-1:0] req_bit;
  logic [RND_W-1:0]  lfsr_q;
  logic              hit, full;
  logic [WAY_W-1:0]  hit_way, free_way, vic_way, wr_way;
  logic [NCORES-1:0] hit_pres, vic_pres, others, wr_pres;
  logic [TAG_W-1:0]  vic_tag;
  logic              owns, need_evict, pend_any, stall, acc;
  logic              cap_evict, fwd_go;
  logic [CNT_W-1:0]  press_cnt;
  logic [NCORES-1:0] binv_q;
  logic [LINE_W-1:0] binv_line_q;
  src_e              src_d;

  assign set_idx    = req_line[SET_W-1:0];
  assign tag_val    = req_line[LINE_W-1:SET_W];
  assign req_bit    = NCORES'(1) << req_core;
  assign vic_way    = lfsr_q[WAY_W-1:0];

  snf_lfsr u_rnd (.clk(clk), .rst_n(rst_n), .state(lfsr_q));

  snf_dir #(.NCORES(NCORES), .TAG_W(TAG_W), .SET_W(SET_W), .WAY_W(WAY_W)) u_dir (
    .clk(clk), .rst_n(rst_n), .lk_set(set_idx), .lk_tag(tag_val), .vic_way(vic_way),
    .hit(hit), .hit_way(hit_way), .hit_pres(hit_pres), .full(full),
    .free_way(free_way), .vic_tag(vic_tag), .vic_pres(vic_pres),
    .wr_en(acc), .wr_way(wr_way), .wr_pres(wr_pres)
  );

  snf_pressure #(.WIN(WIN), .CNT_W(CNT_W)) u_press (
    .clk(clk), .rst_n(rst_n), .ev(cap_evict), .thr_hi(thr_hi), .thr_lo(thr_lo),
    .cnt(press_cnt), .noalloc(noalloc)
  );

  assign owns       = hit && ((hit_pres & req_bit) != '0);
  assign others     = hit_pres & ~req_bit;
  assign need_evict = !hit && full;
  assign pend_any   = |binv_q;
  assign stall      = pend_any && ((req_line == binv_line_q) || need_evict);
  assign req_ready  = !stall;
  assign acc        = req_valid && req_ready;
  assign cap_evict  = acc && need_evict;
  assign fwd_go     = acc && hit && !owns;

  always_comb begin
    if (hit) begin
      wr_way  = hit_way;
      wr_pres = hit_pres | req_bit;
      src_d   = owns ? SRC_OWN : SRC_PEER;
    end else begin
      wr_way  = full ? vic_way : free_way;
      wr_pres = req_bit;
      src_d   = SRC_MEM;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rsp_valid   <= 1'b0;
      rsp_core    <= '0;
      rsp_line    <= '0;
      rsp_src     <= SRC_MEM;
      fwd_valid   <= 1'b0;
      fwd_core    <= '0;
      fwd_line    <= '0;
      fill_valid  <= 1'b0;
      fill_line   <= '0;
      binv_line_q <= '0;
    end else begin
      rsp_valid  <= acc;
      fwd_valid  <= fwd_go;
      fill_valid <= fwd_go;
      if (acc) begin
        rsp_core <= req_core;
        rsp_line <= req_line;
        rsp_src  <= src_d;
      end
      if (fwd_go) begin
        fwd_core  <= lowest_core(others);
        fwd_line  <= req_line;
        fill_line <= req_line;
      end
      if (cap_evict) binv_line_q <= {vic_tag, set_idx};
    end
  end

  for (genvar c = 0; c < NCORES; c++) begin : g_binv
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)                      binv_q[c] <= 1'b0;
      else if (cap_evict && vic_pres[c]) binv_q[c] <= 1'b1;
      else if (binv_ack[c])            binv_q[c] <= 1'b0;
    end
  end

  assign binv_valid = binv_q;
  assign binv_line  = binv_line_q;
endmodule

// File: rtl/snoop_filter_chk.sv
module snoop_filter_chk
  import snf_pkg::*;
#(
  parameter int NCORES = 4,
  parameter int LINE_W = 12,
  parameter int CNT_W  = 9,
  localparam int CID_W = $clog2(NCORES)
) (
  input logic              clk,
  input logic              rst_n,
  input logic              req_valid,
  input logic              req_ready,
  input logic [LINE_W-1:0] req_line,
  input logic              rsp_valid,
  input logic [CID_W-1:0]  rsp_core,
  input logic [1:0]        rsp_src,
  input logic              fwd_valid,
  input logic [CID_W-1:0]  fwd_core,
  input logic [LINE_W-1:0] fwd_line,
  input logic              fill_valid,
  input logic [LINE_W-1:0] fill_line,
  input logic [NCORES-1:0] binv_valid,
  input logic [LINE_W-1:0] binv_line,
  input logic [NCORES-1:0] binv_ack,
  input logic [CNT_W-1:0]  thr_hi,
  input logic [CNT_W-1:0]  thr_lo,
  input logic              noalloc,
  input logic              cap_evict,
  input logic [CNT_W-1:0]  press_cnt,
  input logic [RND_W-1:0]  lfsr_q
);
  p_rsp_follows_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (req_valid && req_ready) |=> rsp_valid);
  p_no_rsp_idle_r2: assert property (@(posedge clk) disable iff (!rst_n)
    !(req_valid && req_ready) |=> !rsp_valid);
  p_fwd_peer_r3: assert property (@(posedge clk) disable iff (!rst_n)
    fwd_valid |-> (rsp_valid && rsp_src == SRC_PEER && fwd_core != rsp_core));
  p_fill_pair_r4: assert property (@(posedge clk) disable iff (!rst_n)
    fwd_valid |-> (fill_valid && fill_line == fwd_line));
  p_own_quiet_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (rsp_valid && rsp_src == SRC_OWN) |-> !fwd_valid && !fill_valid);
  p_evict_binv_r6: assert property (@(posedge clk) disable iff (!rst_n)
    cap_evict |=> binv_valid != '0);
  p_binv_hold_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (binv_valid & ~binv_ack) != '0 |=>
      (binv_valid & $past(binv_valid & ~binv_ack)) == $past(binv_valid & ~binv_ack));
  p_binv_clear_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (binv_valid & binv_ack) != '0 |=> (binv_valid & $past(binv_valid & binv_ack)) == '0);
  p_stall_r8: assert property (@(posedge clk) disable iff (!rst_n)
    ((binv_valid != '0) && req_line == binv_line) |-> !req_ready);
  p_lfsr_live_r9: assert property (@(posedge clk) disable iff (!rst_n)
    lfsr_q != '0 |=> lfsr_q != $past(lfsr_q));
  p_enter_r10: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(noalloc) |-> $past(press_cnt) > $past(thr_hi));
  p_leave_r10: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(noalloc) |-> $past(press_cnt) < $past(thr_lo));
endmodule

bind snoop_filter snoop_filter_chk #(.NCORES(NCORES), .LINE_W(LINE_W), .CNT_W(CNT_W)) u_chk (
  .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_ready(req_ready), .req_line(req_line),
  .rsp_valid(rsp_valid), .rsp_core(rsp_core), .rsp_src(rsp_src),
  .fwd_valid(fwd_valid), .fwd_core(fwd_core), .fwd_line(fwd_line),
  .fill_valid(fill_valid), .fill_line(fill_line),
  .binv_valid(binv_valid), .binv_line(binv_line), .binv_ack(binv_ack),
  .thr_hi(thr_hi), .thr_lo(thr_lo), .noalloc(noalloc),
  .cap_evict(cap_evict), .press_cnt(press_cnt), .lfsr_q(lfsr_q)
);

// File: tb/snoop_filter_tb_top.sv
module snoop_filter_tb_top;
  localparam int CLK_P = 10;
  localparam int NC = 4;
  localparam int LW = 12;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic req_valid = 1'b0;
  logic req_ready;
  logic [1:0] req_core = '0;
  logic [LW-1:0] req_line = '0;
  logic rsp_valid, fwd_valid, fill_valid, noalloc;
  logic [1:0] rsp_core, rsp_src, fwd_core;
  logic [LW-1:0] rsp_line, fwd_line, fill_line, binv_line;
  logic [NC-1:0] binv_valid;
  logic [NC-1:0] binv_ack = '0;
  logic [8:0] thr_hi = 9'd2;
  logic [8:0] thr_lo = 9'd1;

  always #(CLK_P/2) clk = ~clk;

  snoop_filter dut_i (
    .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_ready(req_ready),
    .req_core(req_core), .req_line(req_line), .rsp_valid(rsp_valid), .rsp_core(rsp_core),
    .rsp_line(rsp_line), .rsp_src(rsp_src), .fwd_valid(fwd_valid), .fwd_core(fwd_core),
    .fwd_line(fwd_line), .fill_valid(fill_valid), .fill_line(fill_line),
    .binv_valid(binv_valid), .binv_line(binv_line), .binv_ack(binv_ack),
    .thr_hi(thr_hi), .thr_lo(thr_lo), .noalloc(noalloc)
  );

  int checks = 0;
  int errors = 0;
  bit done = 0;

  task automatic chk(input bit ok, input string what, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s act=%0h exp=%0h", what, act, exp);
    end
  endtask

  // random source mirror, from R9
  logic [15:0] m_rnd;
  always @(posedge clk)
    if (!rst_n) m_rnd <= 16'hACE1;
    else        m_rnd <= {m_rnd[14:0], ^(m_rnd & 16'hB400)};

  // directory reference model
  logic [8:0] m_tag  [8][4];
  logic [3:0] m_pres [8][4];
  bit         m_vld  [8][4];

  typedef struct packed {logic [1:0] core; logic [LW-1:0] line; logic [1:0] src;} exp_t;
  exp_t exp_q[$];

  // scoreboard monitor
  always @(negedge clk) begin
    if (rst_n && rsp_valid) begin
      if (exp_q.size() == 0) chk(0, "R2 unexpected response", rsp_line, 0);
      else begin
        exp_t e;
        e = exp_q.pop_front();
        chk(rsp_core == e.core && rsp_line == e.line, "R2 response core/line",
            {rsp_core, rsp_line}, {e.core, e.line});
        chk(rsp_src == e.src, "R2/R3/R5/R6 response source", rsp_src, e.src);
      end
    end
  end

  function automatic logic [LW-1:0] mk(input int s, input int t);
    return LW'((t << 3) | s);
  endfunction

  task automatic issue(input logic [1:0] core, input logic [LW-1:0] line);
    int s, hw, fw;
    logic [8:0] t;
    logic [1:0] src, fc;
    logic [3:0] bit_c, oth, bexp;
    logic [LW-1:0] bl;
    bit fwd, ev;
    s = int'(line[2:0]); t = line[LW-1:3];
    bit_c = 4'b1 << core;
    hw = -1; fw = -1; fwd = 0; ev = 0; fc = 0; bexp = 0; bl = 0;
    @(negedge clk);
    req_valid = 1; req_core = core; req_line = line;
    #1;
    chk(req_ready == 1'b1, "R8 ready for accepted request", req_ready, 1);
    for (int w = 3; w >= 0; w--) begin
      if (m_vld[s][w] && m_tag[s][w] == t) hw = w;
      if (!m_vld[s][w]) fw = w;
    end
    if (hw >= 0) begin
      if ((m_pres[s][hw] & bit_c) != 0) src = 2'd2;
      else begin
        src = 2'd1; fwd = 1;
        oth = m_pres[s][hw] & ~bit_c;
        for (int c = 3; c >= 0; c--) if (oth[c]) fc = 2'(c);
        m_pres[s][hw] = m_pres[s][hw] | bit_c;
      end
    end else if (fw >= 0) begin
      src = 2'd0;
      m_vld[s][fw] = 1; m_tag[s][fw] = t; m_pres[s][fw] = bit_c;
    end else begin
      int v;
      src = 2'd0; ev = 1;
      v = int'(m_rnd[1:0]);
      bexp = m_pres[s][v]; bl = mk(s, int'(m_tag[s][v]));
      m_tag[s][v] = t; m_pres[s][v] = bit_c;
    end
    exp_q.push_back('{core, line, src});
    @(negedge clk);
    req_valid = 0;
    chk(fwd_valid == fwd, "R3 forward pulse", fwd_valid, fwd);
    chk(fill_valid == fwd, "R4 fill pulse", fill_valid, fwd);
    if (fwd) begin
      chk(fwd_core == fc, "R3 forward target", fwd_core, fc);
      chk(fwd_line == line && fill_line == line, "R4 forward/fill line", fwd_line, line);
    end
    if (ev) begin
      chk(binv_valid == bexp, "R6 back-invalidation holders", binv_valid, bexp);
      chk(binv_line == bl, "R6 back-invalidation line", binv_line, bl);
    end
  endtask

  task automatic ack_partial();
    logic [3:0] prev, one;
    prev = binv_valid; one = prev & (~prev + 4'd1);
    binv_ack = one;
    @(negedge clk);
    binv_ack = 0;
    chk(binv_valid == (prev & ~one), "R7 partial acknowledge", binv_valid, prev & ~one);
  endtask

  task automatic ack_all();
    binv_ack = binv_valid;
    @(negedge clk);
    binv_ack = 0;
    chk(binv_valid == 0, "R7 all acknowledged", binv_valid, 0);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    chk(rsp_valid == 0 && fwd_valid == 0 && fill_valid == 0, "R1 pulses idle in reset", rsp_valid, 0);
    chk(binv_valid == 0 && noalloc == 0 && req_ready == 1, "R1 reset state",
        {binv_valid, noalloc, req_ready}, 1);
    rst_n = 1;
    @(negedge clk);
    chk(binv_valid == 0 && noalloc == 0 && rsp_valid == 0, "R1 after reset", binv_valid, 0);
    // R2: fill set 0, one line per core
    for (int c = 0; c < 4; c++) issue(2'(c), mk(0, c + 1));
    // R3/R4: transfers and holder growth
    issue(2'd1, mk(0, 1));
    issue(2'd2, mk(0, 1));
    issue(2'd3, mk(0, 2));
    // R5: already held
    issue(2'd0, mk(0, 1));
    issue(2'd2, mk(0, 1));
    // R2: another set
    issue(2'd0, mk(1, 1));
    // R6: capacity eviction with random victim
    issue(2'd0, mk(0, 5));
    // R8: stall rules while pending
    @(negedge clk);
    req_valid = 1; req_core = 2'd1; req_line = binv_line;
    #1 chk(req_ready == 0, "R8 stall on pending line", req_ready, 0);
    req_line = mk(0, 6);
    #1 chk(req_ready == 0, "R8 stall on second eviction", req_ready, 0);
    req_valid = 0;
    issue(2'd2, mk(2, 3));
    if ($countones(binv_valid) > 1) ack_partial();
    ack_all();
    // R6: further evictions; victim lines must miss again
    issue(2'd3, mk(0, 6));
    ack_all();
    repeat (2) @(negedge clk);
    chk(noalloc == 0, "R10 count at threshold stays off", noalloc, 0);
    issue(2'd1, mk(0, 7));
    ack_all();
    repeat (2) @(negedge clk);
    chk(noalloc == 1, "R10 enter no-allocate above high threshold", noalloc, 1);
    thr_lo = 9'd0;
    repeat (300) @(negedge clk);
    chk(noalloc == 1, "R10 hysteresis keeps mode", noalloc, 1);
    thr_lo = 9'd1;
    repeat (3) @(negedge clk);
    chk(noalloc == 0, "R10 leave no-allocate below low threshold", noalloc, 0);
    repeat (3) @(negedge clk);
    chk(exp_q.size() == 0, "R2 all responses seen", exp_q.size(), 0);
    if (!done) begin
      done = 1;
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      done = 1;
      checks++; errors++;
      $display("FAIL watchdog expired act=0 exp=1");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end
endmodule